// File: doc/BRIEF.md
# Dual-Section Latched Bidirectional Bus Transceiver

This block moves data between two ports, A and B, through a separate bank of storage latches for each direction. It has two independent sections, 18 bits wide by default. Each direction of each section has three active-low controls: a chip enable, a latch enable and an output enable. The chip enable has two roles. It qualifies loading of the latch, and it qualifies the drive of the far-side port.

While a latch is open, data passes straight from the input port to the opposite output port in the same cycle. Closing the latch holds the last value it saw. The open or closed state is sampled on each clock, so the hold is modelled in a clocked way. Each tri-state port is split into three vectors: an input, an output and a per-bit output enable.

The two sections can be run as two separate 18-bit transceivers. Driving both sections from the same control bits makes them act as one 36-bit transceiver. Each section has a flag that rises when its A and B ports are both enabled to drive at once.

Top module: `dual_latch_xcvr`

## Requirements
- R1: While a direction's chip enable is high, the output-enable vector of the port it drives is all zeros, whatever that direction's latch enable and output enable are doing.
- R2: While a direction's output enable is high, the output-enable vector of the port it drives is all zeros.
- R3: While chip enable, latch enable and output enable are all low, the driven port's output equals the source port's input in the same cycle, and a change at the input shows at the output before the next clock edge.
- R4: When the latch enable goes high while the chip enable is low, the latch keeps the source value present in the last cycle it was open. Later changes at the source input do not reach the output.
- R5: A latch loads only in cycles where both its chip enable and its latch enable are low. A source value presented while the chip enable is high never enters the latch. Once chip enable and output enable are low with latch enable high, the port drives the value stored earlier.
- R6: The B-to-A direction behaves in the same way. Its controls move B-port input data to the A-port output through its own latch bank, and that bank is separate from the A-to-B bank.
- R7: Each section takes only its own controls and data bits: section 0 is bits 17..0 and section 1 is bits 35..18. When both sections are given identical controls, the block behaves as one 36-bit transceiver.
- R8: A synchronous active-high reset clears every latch to zero. While reset is high, every port output-enable vector is forced to all zeros.
- R9: A section's contention flag is 1 exactly when that section's A-port and B-port output enables are both active. Bit 0 of the flag vector is section 0.
- R10: Every port output-enable vector within a section is either all ones or all zeros. One control bit is repeated across all bits of the section.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at which latch state is sampled |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 36 | A-port receive data |
| a_out | output | 36 | A-port transmit data (from the B-to-A latches) |
| a_oe | output | 36 | A-port drive enable, one per bit |
| b_in | input | 36 | B-port receive data |
| b_out | output | 36 | B-port transmit data (from the A-to-B latches) |
| b_oe | output | 36 | B-port drive enable, one per bit |
| ab_ce_n | input | 2 | A-to-B chip enable per section, active low |
| ab_le_n | input | 2 | A-to-B latch enable per section, active low |
| ab_oe_n | input | 2 | A-to-B output enable per section, active low |
| ba_ce_n | input | 2 | B-to-A chip enable per section, active low |
| ba_le_n | input | 2 | B-to-A latch enable per section, active low |
| ba_oe_n | input | 2 | B-to-A output enable per section, active low |
| contend | output | 2 | Per-section flag: A and B drive enabled together |

## Verification
Transparency is tested by changing the input between clock edges. This separates a combinational bypass from a one-cycle-late register. Capture is tested by altering the input in the same cycle the latch enable rises. This shows the stored value is the last open-cycle sample, not the current input. Loading attempts with the chip enable high, and with the output enable high, show that loading and driving are gated apart. Running one section while the other is idle, and then tying both sections to the same controls, shows that the sections are independent. A reset that follows a load shows that the latch contents are cleared.

// File: rtl/dual_latch_xcvr_pkg.sv
package dual_latch_xcvr_pkg;
  localparam int unsigned DEF_SECT_W = 18;
  localparam int unsigned DEF_NUM_SECT = 2;

  typedef struct packed {
    logic ce_n;
    logic le_n;
    logic oe_n;
  } dir_ctl_t;
endpackage

// File: rtl/xcvr_latch_bank.sv
module xcvr_latch_bank
  import dual_latch_xcvr_pkg::*;
#(
  parameter int unsigned W = DEF_SECT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  dir_ctl_t     ctl,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] drv
);
  logic         open_w;
  logic         drive_w;
  logic [W-1:0] store_q;

  assign open_w  = !ctl.ce_n && !ctl.le_n;
  assign drive_w = !rst && !ctl.ce_n && !ctl.oe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
    end else if (open_w) begin
      store_q <= din;
    end
  end

  assign dout = open_w ? din : store_q;
  assign drv  = {W{drive_w}};

  // R1, R2: either control high keeps the port undriven
  a_r1_r2_gate_drive: assert property (@(posedge clk) disable iff (rst)
    (ctl.ce_n || ctl.oe_n) |-> (drv == '0));

  // R4: closing the latch keeps the last open-cycle input
  a_r4_capture: assert property (@(posedge clk) disable iff (rst)
    (!open_w && $past(open_w) && !$past(rst)) |-> (dout == $past(din)));

  // R5: a closed latch keeps its output steady
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!open_w && !$past(open_w) && !$past(rst)) |-> $stable(dout));

  // R8: reset clears storage and forces drive off
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (store_q == '0));
  a_r8_reset_drive: assert property (@(posedge clk)
    rst |-> (drv == '0));

  // R10: the drive vector is uniform across the section
  a_r10_uniform_oe: assert property (@(posedge clk) disable iff (rst)
    (drv == '0) || (drv == '1));
endmodule

// File: rtl/xcvr_section.sv
module xcvr_section
  import dual_latch_xcvr_pkg::*;
#(
  parameter int unsigned W = DEF_SECT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  dir_ctl_t     ab_ctl,
  input  dir_ctl_t     ba_ctl,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  output logic         contend
);
  xcvr_latch_bank #(.W(W)) u_ab (
    .clk  (clk),
    .rst  (rst),
    .ctl  (ab_ctl),
    .din  (a_in),
    .dout (b_out),
    .drv  (b_oe)
  );

  xcvr_latch_bank #(.W(W)) u_ba (
    .clk  (clk),
    .rst  (rst),
    .ctl  (ba_ctl),
    .din  (b_in),
    .dout (a_out),
    .drv  (a_oe)
  );

  assign contend = a_oe[0] && b_oe[0];

  // R9: both ports enabled together raises the flag
  a_r9_contend_set: assert property (@(posedge clk) disable iff (rst)
    ((|a_oe) && (|b_oe)) |-> contend);
  a_r9_contend_clr: assert property (@(posedge clk) disable iff (rst)
    ((a_oe == '0) || (b_oe == '0)) |-> !contend);
endmodule

// File: rtl/dual_latch_xcvr.sv
module dual_latch_xcvr
  import dual_latch_xcvr_pkg::*;
#(
  parameter int unsigned SECT_W   = DEF_SECT_W,
  parameter int unsigned NUM_SECT = DEF_NUM_SECT,
  localparam int unsigned TOT_W   = SECT_W * NUM_SECT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [TOT_W-1:0]    a_in,
  output logic [TOT_W-1:0]    a_out,
  output logic [TOT_W-1:0]    a_oe,
  input  logic [TOT_W-1:0]    b_in,
  output logic [TOT_W-1:0]    b_out,
  output logic [TOT_W-1:0]    b_oe,
  input  logic [NUM_SECT-1:0] ab_ce_n,
  input  logic [NUM_SECT-1:0] ab_le_n,
  input  logic [NUM_SECT-1:0] ab_oe_n,
  input  logic [NUM_SECT-1:0] ba_ce_n,
  input  logic [NUM_SECT-1:0] ba_le_n,
  input  logic [NUM_SECT-1:0] ba_oe_n,
  output logic [NUM_SECT-1:0] contend
);
  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    dir_ctl_t ab_ctl;
    dir_ctl_t ba_ctl;

    assign ab_ctl = '{ce_n: ab_ce_n[s], le_n: ab_le_n[s], oe_n: ab_oe_n[s]};
    assign ba_ctl = '{ce_n: ba_ce_n[s], le_n: ba_le_n[s], oe_n: ba_oe_n[s]};

    xcvr_section #(.W(SECT_W)) u_sect (
      .clk     (clk),
      .rst     (rst),
      .ab_ctl  (ab_ctl),
      .ba_ctl  (ba_ctl),
      .a_in    (a_in [s*SECT_W +: SECT_W]),
      .a_out   (a_out[s*SECT_W +: SECT_W]),
      .a_oe    (a_oe [s*SECT_W +: SECT_W]),
      .b_in    (b_in [s*SECT_W +: SECT_W]),
      .b_out   (b_out[s*SECT_W +: SECT_W]),
      .b_oe    (b_oe [s*SECT_W +: SECT_W]),
      .contend (contend[s])
    );

    // R7: a section's drive follows only its own chip enable
    a_r7_own_ctl: assert property (@(posedge clk) disable iff (rst)
      ab_ce_n[s] |-> (b_oe[s*SECT_W +: SECT_W] == '0));
  end
endmodule

// File: tb/dual_latch_xcvr_bench.sv
`timescale 1ns/1ps
module dual_latch_xcvr_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [35:0] a_in = '0;
  logic [35:0] b_in = '0;
  logic [35:0] a_out, a_oe, b_out, b_oe;
  logic [1:0]  ab_ce_n = 2'b11, ab_le_n = 2'b11, ab_oe_n = 2'b11;
  logic [1:0]  ba_ce_n = 2'b11, ba_le_n = 2'b11, ba_oe_n = 2'b11;
  logic [1:0]  contend;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_latch_xcvr u_dual_latch_xcvr (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
    .contend(contend)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic t_reset_entry();
    ab_ce_n[0] = 1'b0; ab_oe_n[0] = 1'b0;
    repeat (3) tick();
    settle();
    chk("R8 drive off in reset", b_oe, 36'h0);
    chk("R8 a drive off in reset", a_oe, 36'h0);
    tick();
    rst = 1'b0;
    settle();
    chk("R8 latch cleared", {18'h0, b_out[17:0]}, 36'h0);
    chk("R10 drive all ones", {18'h0, b_oe[17:0]}, {18'h0, 18'h3FFFF});
  endtask

  task automatic t_transparent();
    tick();
    ab_ce_n[0] = 1'b0; ab_le_n[0] = 1'b0; ab_oe_n[0] = 1'b0;
    a_in[17:0] = 18'h12345;
    settle();
    chk("R3 pass through", {18'h0, b_out[17:0]}, {18'h0, 18'h12345});
    a_in[17:0] = 18'h2DCBA;
    #1;
    chk("R3 same-cycle follow", {18'h0, b_out[17:0]}, {18'h0, 18'h2DCBA});
  endtask

  task automatic t_capture();
    tick();
    a_in[17:0] = 18'h0F0F0;
    tick();
    ab_le_n[0] = 1'b1;
    a_in[17:0] = 18'h30303;
    settle();
    chk("R4 captured value", {18'h0, b_out[17:0]}, {18'h0, 18'h0F0F0});
    tick();
    settle();
    chk("R4 still held", {18'h0, b_out[17:0]}, {18'h0, 18'h0F0F0});
  endtask

  task automatic t_ce_gate();
    tick();
    ab_ce_n[0] = 1'b1; ab_le_n[0] = 1'b0; ab_oe_n[0] = 1'b0;
    a_in[17:0] = 18'h11111;
    settle();
    chk("R1 ce blocks drive", {18'h0, b_oe[17:0]}, 36'h0);
    ab_le_n[0] = 1'b1;
    #1;
    chk("R1 ce blocks drive le high", {18'h0, b_oe[17:0]}, 36'h0);
    ab_le_n[0] = 1'b0;
    tick();
    tick();
    ab_ce_n[0] = 1'b0; ab_le_n[0] = 1'b1;
    settle();
    chk("R5 no load while ce high", {18'h0, b_out[17:0]}, {18'h0, 18'h0F0F0});
    chk("R5 stored drive on", {18'h0, b_oe[17:0]}, {18'h0, 18'h3FFFF});
  endtask

  task automatic t_oe_gate();
    tick();
    ab_le_n[0] = 1'b0; ab_oe_n[0] = 1'b1;
    a_in[17:0] = 18'h22222;
    settle();
    chk("R2 oe blocks drive", {18'h0, b_oe[17:0]}, 36'h0);
    tick();
    ab_le_n[0] = 1'b1; ab_oe_n[0] = 1'b0;
    settle();
    chk("R5 loaded while oe high", {18'h0, b_out[17:0]}, {18'h0, 18'h22222});
  endtask

  task automatic t_ba_dir();
    tick();
    ba_ce_n[0] = 1'b0; ba_le_n[0] = 1'b0; ba_oe_n[0] = 1'b0;
    b_in[17:0] = 18'h3C3C3;
    settle();
    chk("R6 b to a pass", {18'h0, a_out[17:0]}, {18'h0, 18'h3C3C3});
    chk("R6 a drive on", {18'h0, a_oe[17:0]}, {18'h0, 18'h3FFFF});
    chk("R9 contention section 0", {34'h0, contend}, 36'h1);
    tick();
    ba_le_n[0] = 1'b1;
    b_in[17:0] = 18'h0;
    settle();
    chk("R6 b to a held", {18'h0, a_out[17:0]}, {18'h0, 18'h3C3C3});
    chk("R6 a to b bank untouched", {18'h0, b_out[17:0]}, {18'h0, 18'h22222});
    ab_oe_n[0] = 1'b1;
    #1;
    chk("R9 contention cleared", {34'h0, contend}, 36'h0);
  endtask

  task automatic t_sections();
    tick();
    ab_ce_n = 2'b01; ab_le_n = 2'b01; ab_oe_n = 2'b01;
    ba_ce_n = 2'b11; ba_le_n = 2'b11; ba_oe_n = 2'b11;
    a_in = {18'h15555, 18'h0AAAA};
    settle();
    chk("R7 section 1 passes", {18'h0, b_out[35:18]}, {18'h0, 18'h15555});
    chk("R7 section 1 drive", {18'h0, b_oe[35:18]}, {18'h0, 18'h3FFFF});
    chk("R7 section 0 idle", {18'h0, b_oe[17:0]}, 36'h0);
    tick();
    ab_ce_n = 2'b00; ab_le_n = 2'b00; ab_oe_n = 2'b00;
    a_in = 36'h987654321;
    settle();
    chk("R7 36-bit pass", b_out, 36'h987654321);
    chk("R10 36-bit drive", b_oe, 36'hFFFFFFFFF);
    tick();
    ab_le_n = 2'b11;
    a_in = '0;
    settle();
    chk("R7 36-bit hold", b_out, 36'h987654321);
  endtask

  task automatic t_reset_after_load();
    tick();
    ba_ce_n[0] = 1'b0; ba_le_n[0] = 1'b1; ba_oe_n[0] = 1'b0;
    ab_oe_n = 2'b11;
    rst = 1'b1;
    tick();
    rst = 1'b0;
    ab_oe_n = 2'b00;
    settle();
    chk("R8 a to b cleared", b_out, 36'h0);
    chk("R8 b to a cleared", {18'h0, a_out[17:0]}, 36'h0);
    chk("R8 drive back after reset", b_oe, 36'hFFFFFFFFF);
  endtask

  initial begin
    t_reset_entry();
    t_transparent();
    t_capture();
    t_ce_gate();
    t_oe_gate();
    t_ba_dir();
    t_sections();
    t_reset_after_load();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule